// File: doc/BRIEF.md
# Configurable Output Logic Cell

This block is a single output cell of a registered programmable logic array. The array outside the cell supplies five product terms: a sum term, an output-enable term, and two terms shared by every cell, one that clears the register and one that presets it. The cell also takes a clock and two configuration bits. It drives a tri-state pad, given as a driven value and an enable. It returns a feedback signal to the array in true and complement form.

One configuration bit selects the mode. In registered mode the sum term is captured by a D flip-flop, and the pin shows the stored bit. In combinatorial mode the sum term reaches the pin within the same cycle. The other bit chooses whether the pin is true or inverted. Feedback comes from a different place in each mode. A registered cell feeds back the inverted register output and ignores its pad. A combinatorial cell feeds back the pad level, so an external driver can use the pin as an input.

A test preload port forces any value into the register on the next edge, which lets a test place a state machine in any state. The chip reset is asserted asynchronously and released synchronously.

Top module: `olmc_cell`

## Requirements
- R1: `cfg_comb`=0 selects registered mode and `cfg_comb`=1 selects combinatorial mode. `cfg_act_high`=1 drives the pin true and `cfg_act_high`=0 drives it inverted. All four combinations are legal.
- R2: In registered mode the register captures `sum_term` on each rising clock edge. `pin_drive` equals the register, or its inverse when active-low is selected.
- R3: In registered mode `fb_true` is the inverted register bit and `fb_comp` is the register bit. `pin_in` has no effect on either.
- R4: In combinatorial mode `pin_drive` follows `sum_term` through the polarity stage in the same cycle. `fb_true` equals `pin_drive` while `oe_term`=1 and equals `pin_in` while `oe_term`=0. `fb_comp` is always its complement.
- R5: `pin_oe` follows `oe_term` in every mode.
- R6: `ar_term`=1 clears the register to 0 at once, with no clock edge needed.
- R7: `sp_term`=1 sets the register to 1 on the next rising edge.
- R8: Clear and preset act before the polarity stage. An active-low registered cell shows `pin_drive`=1 after a clear.
- R9: `rst_n`=0 clears the register asynchronously. After `rst_n` rises, the register first captures data on the third rising edge.
- R10: `preload_en`=1 loads `preload_val` into the register on the next rising edge. It takes priority over `sp_term` and `sum_term`.
- R11: When `ar_term` is active together with `sp_term` or `preload_en`, the register stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Chip reset, active low, asserted asynchronously |
| cfg_comb | input | 1 | Mode bit: 0 registered, 1 combinatorial |
| cfg_act_high | input | 1 | Polarity bit: 1 true, 0 inverted |
| sum_term | input | 1 | Sum of the cell's logic product terms |
| oe_term | input | 1 | Output-enable product term |
| ar_term | input | 1 | Shared asynchronous clear term |
| sp_term | input | 1 | Shared synchronous preset term |
| preload_en | input | 1 | Test preload strobe |
| preload_val | input | 1 | Value that the preload forces into the register |
| pin_in | input | 1 | Level seen on the pad when the cell does not drive it |
| pin_drive | output | 1 | Value driven onto the pad |
| pin_oe | output | 1 | Pad driver enable |
| fb_true | output | 1 | Feedback to the array, true form |
| fb_comp | output | 1 | Feedback to the array, complement form |

## Verification
The hardest case to reach is a clear that arrives between clock edges. The register must read 0 before any edge occurs, and it must then win over a preset or preload that is present at the same time. The bench raises `ar_term` just after a falling edge. It checks all outputs within that same half cycle. It then holds `ar_term` across the next rising edge together with `sp_term` and `preload_en`. Pad feedback is covered by toggling `pin_in` while the driver is disabled, once in combinatorial mode, where the feedback must follow the pad, and once in registered mode, where the feedback must not change.

// File: rtl/olmc_pkg.sv
package olmc_pkg;

  // Cell configuration: bit 1 chooses the mode, bit 0 the polarity.
  typedef enum logic [1:0] {
    CFG_REG_LOW   = 2'b00,
    CFG_REG_HIGH  = 2'b01,
    CFG_COMB_LOW  = 2'b10,
    CFG_COMB_HIGH = 2'b11
  } cell_cfg_e;

  function automatic logic cfg_is_comb(cell_cfg_e c);
    return c[1];
  endfunction

  function automatic logic cfg_is_high(cell_cfg_e c);
    return c[0];
  endfunction

  function automatic logic apply_pol(cell_cfg_e c, logic v);
    return cfg_is_high(c) ? v : ~v;
  endfunction

endpackage

// File: rtl/olmc_rst_sync.sv
module olmc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ok
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_ok = chain_q[STAGES-1];

endmodule

// File: rtl/olmc_store.sv
module olmc_store (
  input  logic clk,
  input  logic rst_ok,
  input  logic ar_term,
  input  logic sp_term,
  input  logic load_en,
  input  logic load_val,
  input  logic d_in,
  output logic q
);

  logic clr_n;
  logic q_nxt;

  // The async clear is the chip reset combined with the shared clear term (R6, R9).
  assign clr_n = rst_ok & ~ar_term;

  // Synchronous priority: the preload comes first, then the preset, then the data (R7, R10).
  always_comb begin
    if (load_en)      q_nxt = load_val;
    else if (sp_term) q_nxt = 1'b1;
    else              q_nxt = d_in;
  end

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) q <= 1'b0;
    else        q <= q_nxt;
  end

  assert_ar_clears_R6: assert property (@(posedge clk) disable iff (!rst_ok)
    ar_term |-> !q);

  assert_sp_sets_R7: assert property (@(posedge clk) disable iff (!rst_ok)
    (sp_term && !load_en && !ar_term) |=> (q || ar_term));

  assert_preload_R10: assert property (@(posedge clk) disable iff (!rst_ok)
    (load_en && !ar_term) |=> ((q == $past(load_val)) || ar_term));

  assert_ar_wins_R11: assert property (@(posedge clk) disable iff (!rst_ok)
    (ar_term && (sp_term || load_en)) |=> (!q || !ar_term));

endmodule

// File: rtl/olmc_route.sv
module olmc_route
  import olmc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_ok,
  input  cell_cfg_e cfg,
  input  logic      sum_term,
  input  logic      oe_term,
  input  logic      q,
  input  logic      pin_in,
  output logic      pin_drive,
  output logic      pin_oe,
  output logic      fb_true,
  output logic      fb_comp
);

  logic core;
  logic pad_lvl;

  always_comb begin
    core      = cfg_is_comb(cfg) ? sum_term : q;
    pin_drive = apply_pol(cfg, core);
    pin_oe    = oe_term;
    // Level on the pad side of the driver.
    pad_lvl   = oe_term ? pin_drive : pin_in;
    fb_true   = cfg_is_comb(cfg) ? pad_lvl : ~q;
    fb_comp   = ~fb_true;
  end

  assert_reg_fb_R3: assert property (@(posedge clk) disable iff (!rst_ok)
    !cfg_is_comb(cfg) |-> (fb_comp == (cfg_is_high(cfg) ? pin_drive : ~pin_drive)));

  assert_comb_drv_fb_R4: assert property (@(posedge clk) disable iff (!rst_ok)
    (cfg_is_comb(cfg) && oe_term) |-> (fb_true == pin_drive));

  assert_comb_pad_fb_R4: assert property (@(posedge clk) disable iff (!rst_ok)
    (cfg_is_comb(cfg) && !oe_term) |-> (fb_true == pin_in));

endmodule

// File: rtl/olmc_cell.sv
module olmc_cell
  import olmc_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_comb,
  input  logic cfg_act_high,
  input  logic sum_term,
  input  logic oe_term,
  input  logic ar_term,
  input  logic sp_term,
  input  logic preload_en,
  input  logic preload_val,
  input  logic pin_in,
  output logic pin_drive,
  output logic pin_oe,
  output logic fb_true,
  output logic fb_comp
);

  logic      rst_ok;
  logic      q;
  cell_cfg_e cfg;

  assign cfg = cell_cfg_e'({cfg_comb, cfg_act_high});

  olmc_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ok (rst_ok)
  );

  olmc_store u_store (
    .clk      (clk),
    .rst_ok   (rst_ok),
    .ar_term  (ar_term),
    .sp_term  (sp_term),
    .load_en  (preload_en),
    .load_val (preload_val),
    .d_in     (sum_term),
    .q        (q)
  );

  olmc_route u_route (
    .clk       (clk),
    .rst_ok    (rst_ok),
    .cfg       (cfg),
    .sum_term  (sum_term),
    .oe_term   (oe_term),
    .q         (q),
    .pin_in    (pin_in),
    .pin_drive (pin_drive),
    .pin_oe    (pin_oe),
    .fb_true   (fb_true),
    .fb_comp   (fb_comp)
  );

  // A clear seen at an edge leaves an active-low registered pin high (R8).
  assert_clear_pol_R8: assert property (@(posedge clk) disable iff (!rst_ok)
    (ar_term && !cfg_comb && !cfg_act_high) |-> pin_drive);

endmodule

// File: tb/tb_olmc_cell.sv
module tb_olmc_cell;

  localparam int STAGES = 2;

  logic clk = 1'b0;
  logic rst_n, cfg_comb, cfg_act_high, sum_term, oe_term, ar_term, sp_term;
  logic preload_en, preload_val, pin_in;
  logic pin_drive, pin_oe, fb_true, fb_comp;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic qm;
  int   rel;

  always #10 clk = ~clk;

  olmc_cell #(.RST_STAGES(STAGES)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_comb(cfg_comb), .cfg_act_high(cfg_act_high),
    .sum_term(sum_term), .oe_term(oe_term), .ar_term(ar_term), .sp_term(sp_term),
    .preload_en(preload_en), .preload_val(preload_val), .pin_in(pin_in),
    .pin_drive(pin_drive), .pin_oe(pin_oe), .fb_true(fb_true), .fb_comp(fb_comp)
  );

  // Reference register model, written from the requirements.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qm  <= 1'b0;
      rel <= 0;
    end else begin
      if (rel < STAGES) rel <= rel + 1;
      if (rel < STAGES || ar_term) qm <= 1'b0;
      else if (preload_en)         qm <= preload_val;
      else if (sp_term)            qm <= 1'b1;
      else                         qm <= sum_term;
    end
  end

  task automatic cmp1(string req, string nm, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", req, nm, act, exp, $time);
    end
  endtask

  task automatic chk(string req);
    logic eq, core, ed, lvl, ft;
    eq   = ar_term ? 1'b0 : qm;
    core = cfg_comb ? sum_term : eq;
    ed   = cfg_act_high ? core : ~core;
    lvl  = oe_term ? ed : pin_in;
    ft   = cfg_comb ? lvl : ~eq;
    cmp1(req, "pin_drive", pin_drive, ed);
    cmp1(req, "pin_oe", pin_oe, oe_term);
    cmp1(req, "fb_true", fb_true, ft);
    cmp1(req, "fb_comp", fb_comp, ~ft);
  endtask

  task automatic setv(logic c, logic h, logic s, logic o, logic a, logic p,
                      logic pe, logic pv, logic pi);
    cfg_comb = c; cfg_act_high = h; sum_term = s; oe_term = o; ar_term = a;
    sp_term = p; preload_en = pe; preload_val = pv; pin_in = pi;
  endtask

  // Drive at the falling edge, then compare shortly after.
  task automatic stp(string req, logic c, logic h, logic s, logic o, logic a,
                     logic p, logic pe, logic pv, logic pi);
    @(negedge clk);
    setv(c, h, s, o, a, p, pe, pv, pi);
    #1 chk(req);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    setv(0, 1, 1, 1, 0, 0, 0, 0, 0);
    #1 chk("R9");                 // reset state
    repeat (3) @(negedge clk);
    chk("R9");
    rst_n = 1'b1;
    // First two edges after release must not capture sum_term=1 (R9)
    stp("R9", 0, 1, 1, 1, 0, 0, 0, 0, 0);
    stp("R9", 0, 1, 1, 1, 0, 0, 0, 0, 0);
    stp("R9", 0, 1, 1, 1, 0, 0, 0, 0, 0);
    stp("R9", 0, 1, 0, 1, 0, 0, 0, 0, 0);

    // R1/R2: registered, both polarities
    stp("R2", 0, 1, 1, 1, 0, 0, 0, 0, 0);
    stp("R2", 0, 1, 0, 1, 0, 0, 0, 0, 0);
    stp("R1", 0, 0, 1, 1, 0, 0, 0, 0, 0);
    stp("R1", 0, 0, 1, 1, 0, 0, 0, 0, 0);
    // R3: pad toggling ignored in registered mode, driver off
    stp("R3", 0, 1, 1, 0, 0, 0, 0, 0, 1);
    stp("R3", 0, 1, 1, 0, 0, 0, 0, 0, 0);
    stp("R3", 0, 1, 1, 0, 0, 0, 0, 0, 1);
    // R4/R5: combinatorial, driven and undriven, both polarities
    stp("R4", 1, 1, 1, 1, 0, 0, 0, 0, 0);
    stp("R4", 1, 1, 0, 1, 0, 0, 0, 0, 1);
    stp("R4", 1, 0, 1, 1, 0, 0, 0, 0, 1);
    stp("R5", 1, 0, 1, 0, 0, 0, 0, 0, 1);
    stp("R4", 1, 0, 1, 0, 0, 0, 0, 0, 0);
    stp("R4", 1, 1, 0, 0, 0, 0, 0, 0, 1);
    // R7: preset
    stp("R7", 0, 1, 0, 1, 0, 1, 0, 0, 0);
    stp("R7", 0, 1, 0, 1, 0, 0, 0, 0, 0);
    // R6/R8: clear mid-cycle with active-low output
    stp("R6", 0, 0, 1, 1, 0, 1, 0, 0, 0);
    stp("R8", 0, 0, 1, 1, 1, 0, 0, 0, 0);
    // R11: clear with preset and preload across an edge
    stp("R11", 0, 0, 1, 1, 1, 1, 1, 1, 0);
    stp("R11", 0, 0, 1, 1, 1, 1, 1, 1, 0);
    // R10: preload wins over preset and sum
    stp("R10", 0, 1, 1, 1, 0, 1, 1, 0, 0);
    stp("R10", 0, 1, 1, 1, 0, 0, 0, 0, 0);
    stp("R10", 0, 1, 0, 1, 0, 0, 1, 1, 0);
    stp("R10", 0, 1, 0, 1, 0, 0, 0, 0, 0);

    // Mixed traffic, compared every cycle
    for (int i = 0; i < 400; i++) begin
      logic [15:0] r;
      r = 16'($urandom);
      stp("R2", r[0], r[1], r[2], r[3], (r[6:4] == 3'd0), (r[9:7] == 3'd0),
          (r[12:10] == 3'd0), r[13], r[14]);
    end

    // Chip reset mid-run clears the register (R9)
    stp("R9", 0, 1, 1, 1, 0, 0, 0, 0, 0);
    stp("R9", 0, 1, 1, 1, 0, 0, 0, 0, 0);
    rst_n = 1'b0;
    #1 chk("R9");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule